// File: doc/BRIEF.md
# UART Host Register and Interrupt Unit

This block sits between a processor bus and the serial halves of a UART. A single-cycle access strobe, qualified by three chip-select inputs, is decoded with a register-select bit and a read/write bit into one of four accesses. Two of them are writes, to the transmit holding register or the control register. The other two are reads, of the receive holding register or the status word. Read data is registered and appears on the cycle after the access, marked by a one-cycle valid pulse.

The unit holds the control byte and passes it to the serial logic. The byte sets frame format, break, interrupt enable and transmit request. The unit keeps the transmit holding register and its empty/full state, and moves it to empty on the shifter's load pulse. It captures each received character with its error flags. It drives request-to-send. It synchronises three peripheral handshake inputs and turns their edges and levels into status bits and interrupt events. Each of five interrupt sources is latched on its own and cleared by its own access. One active-low interrupt pin reports them when interrupts are enabled.

Two small state machines carry the transmit side. The holding machine has states HOLD_EMPTY and HOLD_FULL. A character write goes from either state to HOLD_FULL. The shifter load pulse goes from HOLD_FULL to HOLD_EMPTY. A character write in the same cycle as a load pulse wins. The request-to-send machine has states RTS_IDLE and RTS_ACTIVE. It enters RTS_ACTIVE when transmit request is set or the holding register is full. It returns to RTS_IDLE once the holding register is empty, the shifter reports idle and transmit request is clear. In every other case it stays where it is.

Top module: `uart_host_ctrl`

## Requirements
- R1: An access takes place only when `acc_stb` is high with `cs_a`=1, `cs_b_n`=0 and `cs_c`=1. With `{reg_sel, rd_nwr}` = 00 it writes the transmit holding register, 01 reads received data, 10 writes control and 11 reads status. A deselected strobe changes nothing and returns no read.
- R2: Control bits are: 7 transmit request, 6 break, 5 interrupt enable, 4..3 word length (00=5, 01=6, 10=7, 11=8 bits), 2 stop select, 1 even parity, 0 parity inhibit. A control write with bit 7 clear loads all eight bits. A control write with bit 7 set only sets bit 7 and leaves bits 6..0 unchanged. The register is visible on `ctl_word`.
- R3: The status word is, from bit 7 down: holding empty, shift idle (the `tx_shift_idle` input), peripheral-edge flag, external status, framing error, parity error, overrun, data available.
- R4: A read access returns its value on `rdata` with `rd_valid` high exactly one cycle after the access cycle. `rd_valid` is low otherwise.
- R5: A `rx_valid` pulse stores `rx_data` with the bits above the programmed word length forced to zero. It sets data available, which drives `data_avail_n` low. A data read clears data available.
- R6: At each received character, overrun is set if data available was still set and cleared otherwise. Parity error copies `rx_perr` but is held 0 when parity inhibit is set. Framing error copies `rx_ferr`.
- R7: A character write stores `wdata` on `thr_data` and makes the holding register full (`thr_empty_n` high, status bit 7 low). A `tx_load` pulse makes it empty again. A `tx_load` pulse while it is empty has no effect.
- R8: `irq_n` is low only while interrupt enable is set and at least one source is pending. Sources latch even while interrupts are disabled.
- R9: A received character makes the data interrupt pending, and a data read clears it.
- R10: The holding-empty interrupt becomes pending when transmit request and holding-empty become true together, by either one turning on. The transmitter-idle interrupt becomes pending when holding-empty and shift-idle become true together. Both are cleared by a status read or a character write.
- R11: A falling edge on `psi_n` sets status bit 5 and its interrupt. A rising edge on `cts_n` while holding-empty and shift-idle are both true raises an interrupt. A status read clears both sources and bit 5. A rising edge on `cts_n` while the transmitter is busy raises nothing.
- R12: Status bit 4 is high while `es_n` is held low and low while it is high.
- R13: `rts_n` goes low when transmit request is set or the holding register is full. It goes high only when the holding register is empty, shift idle is high and transmit request is clear.
- R14: `rst_n` low clears the control register (so break is off and the serial line stays high), the status flags, all pending interrupts and the receive holding register. After it, `irq_n` and `rts_n` are high and the holding register is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low clear |
| acc_stb | input | 1 | Single-cycle bus access strobe |
| cs_a | input | 1 | Chip select, active high |
| cs_b_n | input | 1 | Chip select, active low |
| cs_c | input | 1 | Chip select, active high |
| reg_sel | input | 1 | 0 = data registers, 1 = control/status |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| wdata | input | 8 | Write data from the bus |
| rdata | output | 8 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| ctl_word | output | 8 | Control register to the serial logic |
| thr_data | output | 8 | Transmit holding register contents |
| thr_empty_n | output | 1 | Low while the holding register is empty |
| tx_load | input | 1 | Pulse: shifter took the holding register |
| tx_shift_idle | input | 1 | Shifter has no character in flight |
| rx_valid | input | 1 | Pulse: receiver finished a character |
| rx_data | input | 8 | Received character |
| rx_perr | input | 1 | Parity mismatch on that character |
| rx_ferr | input | 1 | Missing stop bit on that character |
| data_avail_n | output | 1 | Low while a received character waits |
| irq_n | output | 1 | Active-low interrupt |
| rts_n | output | 1 | Active-low request-to-send |
| cts_n | input | 1 | Clear-to-send from the peripheral |
| psi_n | input | 1 | Peripheral edge-status input |
| es_n | input | 1 | Peripheral level-status input |

## Verification
The bench builds the block with SYNC_STAGES=2. With that setting the peripheral inputs take a known, short path through the synchronisers and edge detectors. Falling and rising edges on `psi_n` and `cts_n`, and the level on `es_n`, can then be checked a few cycles after they are driven. The holding-empty and transmitter-idle interrupts are reached by driving `tx_load` and `tx_shift_idle` by hand. The bench also checks the transitions of both state machines, including a load pulse while empty and request-to-send holding low while the shifter is still busy.

// File: rtl/uart_host_pkg.sv
package uart_host_pkg;

    localparam int BYTE_W = 8;

    // control register bit positions (read by serial logic)
    localparam int CTL_TR  = 7;
    localparam int CTL_BRK = 6;
    localparam int CTL_IE  = 5;
    localparam int CTL_WLH = 4;
    localparam int CTL_WLL = 3;
    localparam int CTL_PI  = 0;

    localparam int MIN_WORD = 5;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_WR_THR,
        ACC_RD_RHR,
        ACC_WR_CTL,
        ACC_RD_STS
    } acc_e;

    typedef enum logic {
        HOLD_EMPTY,
        HOLD_FULL
    } hold_e;

    typedef enum logic {
        RTS_IDLE,
        RTS_ACTIVE
    } rts_e;

endpackage

// File: rtl/uart_host_decode.sv
module uart_host_decode
    import uart_host_pkg::*;
(
    input  logic acc_stb,
    input  logic cs_a,
    input  logic cs_b_n,
    input  logic cs_c,
    input  logic reg_sel,
    input  logic rd_nwr,
    output acc_e acc
);

    logic chosen;

    always_comb begin
        chosen = acc_stb & cs_a & ~cs_b_n & cs_c;
        acc    = ACC_NONE;
        if (chosen) begin
            unique case ({reg_sel, rd_nwr})
                2'b00:   acc = ACC_WR_THR;
                2'b01:   acc = ACC_RD_RHR;
                2'b10:   acc = ACC_WR_CTL;
                default: acc = ACC_RD_STS;
            endcase
        end
    end

endmodule

// File: rtl/uart_host_sync.sv
module uart_host_sync #(
    parameter int               STAGES  = 2,
    parameter int               WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/uart_host_txctl.sv
module uart_host_txctl
    import uart_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_thr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              tx_load,
    input  logic              tx_shift_idle,
    input  logic              tr,
    output logic              thre,
    output logic [BYTE_W-1:0] thr_data,
    output logic              rts_n
);

    hold_e hold_q, hold_d;
    rts_e  rts_q, rts_d;

    // state registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= HOLD_EMPTY;
            rts_q  <= RTS_IDLE;
        end else begin
            hold_q <= hold_d;
            rts_q  <= rts_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      thr_data <= '0;
        else if (wr_thr) thr_data <= wdata;
    end

    // next-state logic
    always_comb begin
        hold_d = hold_q;
        unique case (hold_q)
            HOLD_EMPTY: if (wr_thr) hold_d = HOLD_FULL;
            HOLD_FULL:  if (!wr_thr && tx_load) hold_d = HOLD_EMPTY;
        endcase

        rts_d = rts_q;
        unique case (rts_q)
            RTS_IDLE:   if (tr || hold_q == HOLD_FULL) rts_d = RTS_ACTIVE;
            RTS_ACTIVE: if (!tr && hold_q == HOLD_EMPTY && tx_shift_idle)
                            rts_d = RTS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        thre  = (hold_q == HOLD_EMPTY);
        rts_n = (rts_q == RTS_IDLE);
    end

    assert_write_fills_R7: assert property (
        @(posedge clk) disable iff (!rst_n) wr_thr |=> !thre);

    assert_tr_drives_rts_R13: assert property (
        @(posedge clk) disable iff (!rst_n) tr |=> !rts_n);

endmodule

// File: rtl/uart_host_irq.sv
module uart_host_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic ie,
    input  logic tr,
    input  logic thre,
    input  logic tsre,
    input  logic rx_load,
    input  logic rd_data,
    input  logic rd_sts,
    input  logic wr_thr,
    input  logic psi_fall,
    input  logic cts_rise,
    output logic irq_n,
    output logic psi_flag
);

    logic pend_da, pend_thre, pend_idle, pend_psi, pend_cts;
    logic thre_cond_d, idle_cond_d;
    logic thre_cond, idle_cond;
    logic thre_ev, idle_ev, cts_ev;
    logic tx_clear;

    always_comb begin
        thre_cond = tr & thre;
        idle_cond = thre & tsre;
        thre_ev   = thre_cond & ~thre_cond_d;
        idle_ev   = idle_cond & ~idle_cond_d;
        cts_ev    = cts_rise & idle_cond;
        tx_clear  = rd_sts | wr_thr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thre_cond_d <= 1'b0;
            idle_cond_d <= 1'b1;
            pend_da     <= 1'b0;
            pend_thre   <= 1'b0;
            pend_idle   <= 1'b0;
            pend_psi    <= 1'b0;
            pend_cts    <= 1'b0;
        end else begin
            thre_cond_d <= thre_cond;
            idle_cond_d <= idle_cond;
            // a new event wins over a clearing access in the same cycle
            if (rx_load)       pend_da   <= 1'b1;
            else if (rd_data)  pend_da   <= 1'b0;
            if (thre_ev)       pend_thre <= 1'b1;
            else if (tx_clear) pend_thre <= 1'b0;
            if (idle_ev)       pend_idle <= 1'b1;
            else if (tx_clear) pend_idle <= 1'b0;
            if (psi_fall)      pend_psi  <= 1'b1;
            else if (rd_sts)   pend_psi  <= 1'b0;
            if (cts_ev)        pend_cts  <= 1'b1;
            else if (rd_sts)   pend_cts  <= 1'b0;
        end
    end

    always_comb begin
        irq_n    = ~(ie & (pend_da | pend_thre | pend_idle | pend_psi | pend_cts));
        psi_flag = pend_psi;
    end

    assert_rx_sets_da_R9: assert property (
        @(posedge clk) disable iff (!rst_n) rx_load |=> pend_da);

    assert_sts_clears_psi_R11: assert property (
        @(posedge clk) disable iff (!rst_n) (rd_sts && !psi_fall) |=> !pend_psi);

    assert_write_clears_thre_R10: assert property (
        @(posedge clk) disable iff (!rst_n) (wr_thr && !thre_ev) |=> !pend_thre);

endmodule

// File: rtl/uart_host_ctrl.sv
module uart_host_ctrl
    import uart_host_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_stb,
    input  logic              cs_a,
    input  logic              cs_b_n,
    input  logic              cs_c,
    input  logic              reg_sel,
    input  logic              rd_nwr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] ctl_word,
    output logic [BYTE_W-1:0] thr_data,
    output logic              thr_empty_n,
    input  logic              tx_load,
    input  logic              tx_shift_idle,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    output logic              data_avail_n,
    output logic              irq_n,
    output logic              rts_n,
    input  logic              cts_n,
    input  logic              psi_n,
    input  logic              es_n
);

    localparam int PERIPH_W = 3;

    acc_e acc;
    logic [BYTE_W-1:0] ctl_q, rhr_q, status;
    logic da_q, oe_q, pe_q, fe_q;
    logic thre, psi_flag;
    logic [PERIPH_W-1:0] periph_s;
    logic cts_s, psi_s, es_s, cts_prev, psi_prev;
    logic psi_fall, cts_rise;
    logic wr_thr, rd_rhr, wr_ctl, rd_sts;

    function automatic logic [BYTE_W-1:0] len_mask(input logic [1:0] wl);
        logic [BYTE_W-1:0] m;
        for (int i = 0; i < BYTE_W; i++)
            m[i] = (i < MIN_WORD + int'(wl));
        return m;
    endfunction

    uart_host_decode u_dec (
        .acc_stb (acc_stb),
        .cs_a    (cs_a),
        .cs_b_n  (cs_b_n),
        .cs_c    (cs_c),
        .reg_sel (reg_sel),
        .rd_nwr  (rd_nwr),
        .acc     (acc)
    );

    always_comb begin
        wr_thr = (acc == ACC_WR_THR);
        rd_rhr = (acc == ACC_RD_RHR);
        wr_ctl = (acc == ACC_WR_CTL);
        rd_sts = (acc == ACC_RD_STS);
    end

    uart_host_sync #(
        .STAGES  (SYNC_STAGES),
        .WIDTH   (PERIPH_W),
        .RST_VAL ('1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cts_n, psi_n, es_n}),
        .q     (periph_s)
    );

    assign {cts_s, psi_s, es_s} = periph_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cts_prev <= 1'b1;
            psi_prev <= 1'b1;
        end else begin
            cts_prev <= cts_s;
            psi_prev <= psi_s;
        end
    end

    assign psi_fall = psi_prev & ~psi_s;
    assign cts_rise = ~cts_prev & cts_s;

    // control register: a write with the request bit set touches nothing else
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctl_q <= '0;
        else if (wr_ctl) begin
            if (wdata[CTL_TR]) ctl_q[CTL_TR] <= 1'b1;
            else               ctl_q <= wdata;
        end
    end

    // receive holding register and receive flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rhr_q <= '0;
            da_q  <= 1'b0;
            oe_q  <= 1'b0;
            pe_q  <= 1'b0;
            fe_q  <= 1'b0;
        end else if (rx_valid) begin
            rhr_q <= rx_data & len_mask(ctl_q[CTL_WLH:CTL_WLL]);
            da_q  <= 1'b1;
            oe_q  <= da_q;
            pe_q  <= rx_perr & ~ctl_q[CTL_PI];
            fe_q  <= rx_ferr;
        end else if (rd_rhr) begin
            da_q  <= 1'b0;
        end
    end

    uart_host_txctl u_tx (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_thr        (wr_thr),
        .wdata         (wdata),
        .tx_load       (tx_load),
        .tx_shift_idle (tx_shift_idle),
        .tr            (ctl_q[CTL_TR]),
        .thre          (thre),
        .thr_data      (thr_data),
        .rts_n         (rts_n)
    );

    uart_host_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ie       (ctl_q[CTL_IE]),
        .tr       (ctl_q[CTL_TR]),
        .thre     (thre),
        .tsre     (tx_shift_idle),
        .rx_load  (rx_valid),
        .rd_data  (rd_rhr),
        .rd_sts   (rd_sts),
        .wr_thr   (wr_thr),
        .psi_fall (psi_fall),
        .cts_rise (cts_rise),
        .irq_n    (irq_n),
        .psi_flag (psi_flag)
    );

    assign status = {thre, tx_shift_idle, psi_flag, ~es_s, fe_q, pe_q, oe_q, da_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata    <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_rhr | rd_sts;
            if (rd_rhr)      rdata <= rhr_q;
            else if (rd_sts) rdata <= status;
        end
    end

    assign ctl_word     = ctl_q;
    assign thr_empty_n  = ~thre;
    assign data_avail_n = ~da_q;

    assert_access_needs_strobe_R1: assert property (
        @(posedge clk) disable iff (!rst_n) (acc != ACC_NONE) |-> acc_stb);

    assert_tr_write_keeps_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        (wr_ctl && wdata[CTL_TR]) |=> (ctl_q[CTL_TR] && ctl_q[6:0] == $past(ctl_q[6:0])));

    assert_read_returns_R4: assert property (
        @(posedge clk) disable iff (!rst_n) (rd_rhr || rd_sts) |=> rd_valid);

    assert_data_read_clears_R5: assert property (
        @(posedge clk) disable iff (!rst_n) (rd_rhr && !rx_valid) |=> !da_q);

endmodule

// File: tb/uart_host_ctrl_test.sv
`timescale 1ns/1ps
module uart_host_ctrl_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_stb = 0, cs_a = 1, cs_b_n = 0, cs_c = 1, reg_sel = 0, rd_nwr = 0;
    logic [7:0] wdata = 0, rx_data = 0;
    logic tx_load = 0, tx_shift_idle = 1, rx_valid = 0, rx_perr = 0, rx_ferr = 0;
    logic cts_n = 1, psi_n = 1, es_n = 1;
    logic [7:0] rdata, ctl_word, thr_data;
    logic rd_valid, thr_empty_n, data_avail_n, irq_n, rts_n;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    uart_host_ctrl #(.SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .cs_a(cs_a), .cs_b_n(cs_b_n),
        .cs_c(cs_c), .reg_sel(reg_sel), .rd_nwr(rd_nwr), .wdata(wdata),
        .rdata(rdata), .rd_valid(rd_valid), .ctl_word(ctl_word), .thr_data(thr_data),
        .thr_empty_n(thr_empty_n), .tx_load(tx_load), .tx_shift_idle(tx_shift_idle),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
        .data_avail_n(data_avail_n), .irq_n(irq_n), .rts_n(rts_n),
        .cts_n(cts_n), .psi_n(psi_n), .es_n(es_n)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic access(input logic rs, input logic rw, input logic [7:0] d);
        acc_stb = 1; reg_sel = rs; rd_nwr = rw; wdata = d;
        @(negedge clk);
        acc_stb = 0;
    endtask

    task automatic wr_ctl(input logic [7:0] d); access(1, 0, d); endtask
    task automatic wr_thr(input logic [7:0] d); access(0, 0, d); endtask
    task automatic rd_sts(output logic [7:0] v); access(1, 1, 0); v = rdata; endtask
    task automatic rd_dat(output logic [7:0] v); access(0, 1, 0); v = rdata; endtask

    task automatic rx_char(input logic [7:0] d, input logic pe, input logic fe);
        rx_valid = 1; rx_data = d; rx_perr = pe; rx_ferr = fe;
        @(negedge clk);
        rx_valid = 0; rx_perr = 0; rx_ferr = 0;
    endtask

    task automatic load_pulse();
        tx_load = 1;
        @(negedge clk);
        tx_load = 0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R14 ctl after reset", ctl_word, 8'h00);
        chk("R14 irq_n after reset", {7'b0, irq_n}, 8'h01);
        chk("R14 rts_n after reset", {7'b0, rts_n}, 8'h01);
        chk("R14 holding empty after reset", {7'b0, thr_empty_n}, 8'h00);
        chk("R14 data_avail_n after reset", {7'b0, data_avail_n}, 8'h01);
        chk("R4 rd_valid idle", {7'b0, rd_valid}, 8'h00);
        rd_sts(v);
        chk("R3 status after reset", v, 8'hC0);
        chk("R4 rd_valid after read", {7'b0, rd_valid}, 8'h01);
        cyc(1);
        chk("R4 rd_valid drops", {7'b0, rd_valid}, 8'h00);
    endtask

    task automatic t_decode();
        cs_b_n = 1; wr_ctl(8'h55); cs_b_n = 0;
        chk("R1 cs_b_n high ignored", ctl_word, 8'h00);
        cs_a = 0; wr_ctl(8'h55); cs_a = 1;
        chk("R1 cs_a low ignored", ctl_word, 8'h00);
        cs_c = 0; access(1, 1, 0); cs_c = 1;
        chk("R1 deselected read no valid", {7'b0, rd_valid}, 8'h00);
        reg_sel = 1; rd_nwr = 0; wdata = 8'h55; cyc(1);
        chk("R1 no strobe ignored", ctl_word, 8'h00);
        wr_ctl(8'h55);
        chk("R1 selected write", ctl_word, 8'h55);
    endtask

    task automatic t_ctl();
        wr_ctl(8'h1D);
        chk("R2 format write", ctl_word, 8'h1D);
        wr_ctl(8'h82);
        chk("R2 request write keeps others", ctl_word, 8'h9D);
        wr_ctl(8'h1C);
        chk("R2 full reload clears request", ctl_word, 8'h1C);
        wr_ctl(8'h00);
    endtask

    task automatic t_rx();
        logic [7:0] v;
        wr_ctl(8'h01);
        rx_char(8'hFF, 1, 0);
        chk("R5 data_avail_n low", {7'b0, data_avail_n}, 8'h00);
        rd_sts(v);
        chk("R6 inhibit masks parity", v & 8'h0F, 8'h01);
        rd_dat(v);
        chk("R5 5-bit mask", v, 8'h1F);
        chk("R5 read clears avail", {7'b0, data_avail_n}, 8'h01);
        wr_ctl(8'h18);
        rx_char(8'hA5, 1, 1);
        rd_sts(v);
        chk("R6 parity and framing", v & 8'h0F, 8'h0D);
        rx_char(8'h3C, 0, 0);
        rd_sts(v);
        chk("R6 overrun set", v & 8'h0F, 8'h03);
        rd_dat(v);
        chk("R5 8-bit data", v, 8'h3C);
        rx_char(8'h81, 0, 0);
        rd_sts(v);
        chk("R6 overrun cleared", v & 8'h0F, 8'h01);
        rd_dat(v);
        wr_ctl(8'h08);
        rx_char(8'hFF, 0, 0);
        rd_dat(v);
        chk("R5 6-bit mask", v, 8'h3F);
        wr_ctl(8'h10);
        rx_char(8'hFF, 0, 0);
        rd_dat(v);
        chk("R5 7-bit mask", v, 8'h7F);
        wr_ctl(8'h00);
    endtask

    task automatic t_hold();
        logic [7:0] v;
        wr_thr(8'hA5);
        chk("R7 holding full", {7'b0, thr_empty_n}, 8'h01);
        chk("R7 holding data", thr_data, 8'hA5);
        rd_sts(v);
        chk("R3 status bit7 low when full", v & 8'h80, 8'h00);
        load_pulse();
        chk("R7 load empties", {7'b0, thr_empty_n}, 8'h00);
        load_pulse();
        chk("R7 load while empty no effect", {7'b0, thr_empty_n}, 8'h00);
        chk("R7 data kept", thr_data, 8'hA5);
        cyc(2);
        rd_sts(v);
        chk("R3 status bit7 high when empty", v & 8'hC0, 8'hC0);
    endtask

    task automatic t_irq_da();
        logic [7:0] v;
        rx_char(8'h11, 0, 0);
        cyc(1);
        chk("R8 masked while disabled", {7'b0, irq_n}, 8'h01);
        wr_ctl(8'h20);
        chk("R8 enable exposes pending", {7'b0, irq_n}, 8'h00);
        rd_dat(v);
        chk("R9 data read clears", {7'b0, irq_n}, 8'h01);
        rx_char(8'h22, 0, 0);
        chk("R9 receive raises", {7'b0, irq_n}, 8'h00);
        rd_dat(v);
        chk("R9 cleared again", {7'b0, irq_n}, 8'h01);
    endtask

    task automatic t_irq_tx();
        logic [7:0] v;
        wr_ctl(8'hA0);
        chk("R2 request with enable", ctl_word, 8'hA0);
        cyc(2);
        chk("R10 request on empty raises", {7'b0, irq_n}, 8'h00);
        rd_sts(v);
        cyc(1);
        chk("R10 status read clears", {7'b0, irq_n}, 8'h01);
        wr_thr(8'h5A);
        tx_shift_idle = 0;
        load_pulse();
        cyc(2);
        chk("R10 empty again raises", {7'b0, irq_n}, 8'h00);
        wr_thr(8'h66);
        cyc(1);
        chk("R10 char write clears", {7'b0, irq_n}, 8'h01);
        load_pulse();
        cyc(2);
        chk("R10 raised after load", {7'b0, irq_n}, 8'h00);
        rd_sts(v);
        cyc(1);
        chk("R10 cleared by status", {7'b0, irq_n}, 8'h01);
        tx_shift_idle = 1;
        cyc(3);
        chk("R10 transmitter idle raises", {7'b0, irq_n}, 8'h00);
        rd_sts(v);
        cyc(1);
        chk("R10 idle cleared", {7'b0, irq_n}, 8'h01);
        wr_ctl(8'h20);
    endtask

    task automatic t_rts();
        logic [7:0] v;
        cyc(2);
        chk("R13 released when empty", {7'b0, rts_n}, 8'h01);
        wr_ctl(8'hA0);
        cyc(2);
        chk("R13 request drives low", {7'b0, rts_n}, 8'h00);
        wr_ctl(8'h20);
        cyc(2);
        chk("R13 release after request off", {7'b0, rts_n}, 8'h01);
        rd_sts(v);
        wr_thr(8'h01);
        cyc(2);
        chk("R13 full drives low", {7'b0, rts_n}, 8'h00);
        tx_shift_idle = 0;
        load_pulse();
        cyc(3);
        chk("R13 held while shifting", {7'b0, rts_n}, 8'h00);
        tx_shift_idle = 1;
        cyc(3);
        chk("R13 release when idle", {7'b0, rts_n}, 8'h01);
        rd_sts(v);
        cyc(1);
    endtask

    task automatic t_periph();
        logic [7:0] v;
        psi_n = 0;
        cyc(5);
        chk("R11 psi fall raises", {7'b0, irq_n}, 8'h00);
        rd_sts(v);
        chk("R11 status bit5 set", v & 8'h20, 8'h20);
        cyc(1);
        chk("R11 status read clears irq", {7'b0, irq_n}, 8'h01);
        rd_sts(v);
        chk("R11 status bit5 cleared", v & 8'h20, 8'h00);
        psi_n = 1;
        cyc(5);
        chk("R11 psi rise no effect", {7'b0, irq_n}, 8'h01);
        cts_n = 0;
        cyc(5);
        chk("R11 cts fall no effect", {7'b0, irq_n}, 8'h01);
        cts_n = 1;
        cyc(5);
        chk("R11 cts rise while idle raises", {7'b0, irq_n}, 8'h00);
        rd_sts(v);
        cyc(1);
        chk("R11 cts cleared by status", {7'b0, irq_n}, 8'h01);
        wr_thr(8'h77);
        cts_n = 0;
        cyc(5);
        cts_n = 1;
        cyc(5);
        chk("R11 cts rise while busy ignored", {7'b0, irq_n}, 8'h01);
        load_pulse();
        cyc(2);
        rd_sts(v);
        cyc(1);
        es_n = 0;
        cyc(4);
        rd_sts(v);
        chk("R12 es low sets bit4", v & 8'h10, 8'h10);
        es_n = 1;
        cyc(4);
        rd_sts(v);
        chk("R12 es high clears bit4", v & 8'h10, 8'h00);
    endtask

    task automatic t_reset_mid();
        logic [7:0] v;
        wr_ctl(8'h7F);
        wr_thr(8'h12);
        rx_char(8'h99, 0, 0);
        rst_n = 0;
        cyc(2);
        rst_n = 1;
        cyc(1);
        chk("R14 control cleared, break off", ctl_word, 8'h00);
        chk("R14 avail cleared", {7'b0, data_avail_n}, 8'h01);
        chk("R14 holding empty", {7'b0, thr_empty_n}, 8'h00);
        chk("R14 irq released", {7'b0, irq_n}, 8'h01);
        chk("R14 rts released", {7'b0, rts_n}, 8'h01);
        rd_dat(v);
        chk("R14 receive register cleared", v, 8'h00);
    endtask

    initial begin
        cyc(3);
        rst_n = 1;
        cyc(1);
        t_reset();
        t_decode();
        t_ctl();
        t_rx();
        t_hold();
        t_irq_da();
        t_irq_tx();
        t_rts();
        wr_ctl(8'h20);
        t_periph();
        t_reset_mid();
        cyc(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule